// File: doc/BRIEF.md
# Flyback-Synchronized Beam Current Sampler

This block takes one set of three 8-bit beam current readings per video frame. It counts scan lines from the rising edge of vertical sync and compares the count with a programmable trigger line number. On the first rising edge of the horizontal flyback pulse that falls on the chosen line, it emits a one-cycle trigger pulse and a one-cycle conversion request to each of three converter channels (red, green, blue). The trigger pulse also serves as the start event for a separate video timing analyzer.

Each channel answers its request with a one-cycle valid strobe and an 8-bit code, in any order and after any latency. The block holds the codes it has received until all three are in. It then writes them into the result registers in a single cycle and raises a "fresh data" flag. A host reads the results through a small registered read port. Reading the red result clears the flag.

Top module: `beam_sampler_top`

## Requirements
- R1: After reset, all three results read 0, the fresh flag is 0, and no trigger pulse or conversion request is issued.
- R2: The line count becomes 0 on a rising edge of vsync_in and then goes up by one on each rising edge of hsync_in. The interval before the first hsync edge of a frame is line 0.
- R3: A capture starts only once a vsync rising edge has been seen since reset. It starts on a rising edge of flyback_in while the line count equals trig_line. It produces exactly one single-cycle trig_pulse, and in that same cycle a single-cycle request on all three adc_req bits (bit 0 red, bit 1 green, bit 2 blue).
- R4: Within one frame, at most one capture starts. Further flyback edges on the trigger line of that frame produce no pulse and no request.
- R5: A frame that never reaches the trigger line produces no capture and leaves the results and the fresh flag unchanged.
- R6: The result registers keep their previous values until all three requested codes have arrived. They then change together in one cycle.
- R7: An adc_valid strobe that arrives when no conversion is outstanding has no effect on the results or on the fresh flag.
- R8: The fresh flag is set in the same cycle that a new result set is stored. It is cleared by a host read of address 0. If both happen in the same cycle, the set wins.
- R9: A read with rd_en high returns data on rd_data one cycle later. Address 0 returns red, 1 returns green, 2 returns blue, and 3 returns the fresh flag in bit 0 with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| flyback_in | input | 1 | Horizontal flyback pulse, active high |
| trig_line | input | LINE_W | Line number on which to sample |
| adc_req | output | 3 | Conversion request strobe per channel (0 red, 1 green, 2 blue) |
| adc_valid | input | 3 | Conversion done strobe per channel |
| adc_code_red | input | CODE_W | Red converter code |
| adc_code_grn | input | CODE_W | Green converter code |
| adc_code_blu | input | CODE_W | Blue converter code |
| trig_pulse | output | 1 | One-cycle trigger line event for the timing analyzer |
| res_red | output | CODE_W | Stored red result |
| res_grn | output | CODE_W | Stored green result |
| res_blu | output | CODE_W | Stored blue result |
| fresh | output | 1 | New result set stored and not yet read |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 2 | Host read address |
| rd_data | output | CODE_W | Host read data, one cycle after rd_en |

## Verification
Frames are driven with the trigger on line 0, on a middle line and on the last line, which separates correct line counting from off-by-one counting. Flyback edges before any vsync, and a frame whose trigger line is never reached, show that arming and the line match both gate the capture. A frame with two flyback pulses per line, the second one after the conversion has finished, separates once-per-frame gating from plain busy blocking. The three converter latencies differ, so a check made when only some codes have arrived shows whether the update is atomic. Valid strobes with no request outstanding show that unsolicited codes are dropped.

// File: rtl/beam_pkg.sv
package beam_pkg;
  localparam int NCH       = 3;
  localparam int CH_RED    = 0;
  localparam int CH_GRN    = 1;
  localparam int CH_BLU    = 2;
  localparam int RD_ADDR_W = 2;

  typedef enum logic [RD_ADDR_W-1:0] {
    SEL_RED  = 2'd0,
    SEL_GRN  = 2'd1,
    SEL_BLU  = 2'd2,
    SEL_STAT = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/beam_line_tracker.sv
module beam_line_tracker #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              fly_in,
  output logic              vs_rise,
  output logic              fly_rise,
  output logic [LINE_W-1:0] line_cnt
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [2:0] smp_q;
  logic [2:0] smp_d1;
  logic [2:0] rise;
  logic       hs_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= '0;
      smp_d1 <= '0;
    end else begin
      smp_q  <= {fly_in, vs_in, hs_in};
      smp_d1 <= smp_q;
    end
  end

  assign rise     = smp_q & ~smp_d1;
  assign hs_rise  = rise[0];
  assign vs_rise  = rise[1];
  assign fly_rise = rise[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt <= '0;
    end else if (vs_rise) begin
      line_cnt <= '0;
    end else if (hs_rise && line_cnt != LINE_MAX) begin
      line_cnt <= line_cnt + 1'b1;
    end
  end

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    vs_rise |=> (line_cnt == '0)); // R2
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    (hs_rise && !vs_rise && line_cnt != LINE_MAX) |=> (line_cnt == $past(line_cnt) + 1'b1)); // R2
endmodule

// File: rtl/beam_capture_ctrl.sv
module beam_capture_ctrl
  import beam_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int CODE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        vs_rise,
  input  logic                        fly_rise,
  input  logic [LINE_W-1:0]           line_cnt,
  input  logic [LINE_W-1:0]           trig_line,
  input  logic [NCH-1:0]              adc_valid,
  input  logic [NCH-1:0][CODE_W-1:0]  adc_code,
  output logic                        trig_pulse,
  output logic [NCH-1:0]              adc_req,
  output logic                        load,
  output logic [NCH-1:0][CODE_W-1:0]  load_data
);
  logic           armed;
  logic           busy;
  logic           fire;
  logic           all_in;
  logic [NCH-1:0] got;

  assign fire   = armed && !busy && fly_rise && (line_cnt == trig_line);
  assign all_in = &(got | adc_valid);
  assign load   = busy && all_in;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic              req_q;
    logic              got_q;
    logic [CODE_W-1:0] held_q;
    logic              take;

    assign take = busy && adc_valid[ch] && !got_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q  <= 1'b0;
        got_q  <= 1'b0;
        held_q <= '0;
      end else begin
        req_q <= fire;
        if (fire) begin
          got_q <= 1'b0;
        end else if (take) begin
          got_q  <= 1'b1;
          held_q <= adc_code[ch];
        end
      end
    end

    assign adc_req[ch]   = req_q;
    assign got[ch]       = got_q;
    assign load_data[ch] = take ? adc_code[ch] : held_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      busy       <= 1'b0;
      trig_pulse <= 1'b0;
    end else begin
      trig_pulse <= fire;
      if (vs_rise) begin
        armed <= 1'b1;
      end else if (fire) begin
        armed <= 1'b0;
      end
      if (fire) begin
        busy <= 1'b1;
      end else if (load) begin
        busy <= 1'b0;
      end
    end
  end

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |=> !trig_pulse); // R3
  AST_REQ_WITH_TRIG: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |-> (adc_req == '1)); // R3
  AST_ONCE_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
    (trig_pulse && !$past(vs_rise)) |-> !armed); // R4
endmodule

// File: rtl/beam_result_bank.sv
module beam_result_bank
  import beam_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [NCH-1:0][CODE_W-1:0]  load_data,
  input  logic                        rd_en,
  input  logic [RD_ADDR_W-1:0]        rd_addr,
  output logic [CODE_W-1:0]           rd_data,
  output logic [NCH-1:0][CODE_W-1:0]  res,
  output logic                        fresh
);
  logic [CODE_W-1:0] rd_mux;
  logic              red_read;

  assign red_read = rd_en && (rd_sel_e'(rd_addr) == SEL_RED);

  always_comb begin
    case (rd_sel_e'(rd_addr))
      SEL_RED:  rd_mux = res[CH_RED];
      SEL_GRN:  rd_mux = res[CH_GRN];
      SEL_BLU:  rd_mux = res[CH_BLU];
      SEL_STAT: rd_mux = {{(CODE_W-1){1'b0}}, fresh};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      fresh   <= 1'b0;
      rd_data <= '0;
    end else begin
      if (load) begin
        res <= load_data;
      end
      if (load) begin
        fresh <= 1'b1;
      end else if (red_read) begin
        fresh <= 1'b0;
      end
      if (rd_en) begin
        rd_data <= rd_mux;
      end
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(res)); // R6
  AST_FRESH_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> fresh); // R8
  AST_FRESH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (red_read && !load) |=> !fresh); // R8
endmodule

// File: rtl/beam_sampler_top.sv
module beam_sampler_top
  import beam_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int CODE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hsync_in,
  input  logic                 vsync_in,
  input  logic                 flyback_in,
  input  logic [LINE_W-1:0]    trig_line,
  output logic [NCH-1:0]       adc_req,
  input  logic [NCH-1:0]       adc_valid,
  input  logic [CODE_W-1:0]    adc_code_red,
  input  logic [CODE_W-1:0]    adc_code_grn,
  input  logic [CODE_W-1:0]    adc_code_blu,
  output logic                 trig_pulse,
  output logic [CODE_W-1:0]    res_red,
  output logic [CODE_W-1:0]    res_grn,
  output logic [CODE_W-1:0]    res_blu,
  output logic                 fresh,
  input  logic                 rd_en,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [CODE_W-1:0]    rd_data
);
  logic                       vs_rise;
  logic                       fly_rise;
  logic [LINE_W-1:0]          line_cnt;
  logic                       load;
  logic [NCH-1:0][CODE_W-1:0] code_vec;
  logic [NCH-1:0][CODE_W-1:0] load_data;
  logic [NCH-1:0][CODE_W-1:0] res;

  assign code_vec[CH_RED] = adc_code_red;
  assign code_vec[CH_GRN] = adc_code_grn;
  assign code_vec[CH_BLU] = adc_code_blu;

  beam_line_tracker #(.LINE_W(LINE_W)) i_tracker (
    .clk      (clk),
    .rst      (rst),
    .hs_in    (hsync_in),
    .vs_in    (vsync_in),
    .fly_in   (flyback_in),
    .vs_rise  (vs_rise),
    .fly_rise (fly_rise),
    .line_cnt (line_cnt)
  );

  beam_capture_ctrl #(.LINE_W(LINE_W), .CODE_W(CODE_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .vs_rise    (vs_rise),
    .fly_rise   (fly_rise),
    .line_cnt   (line_cnt),
    .trig_line  (trig_line),
    .adc_valid  (adc_valid),
    .adc_code   (code_vec),
    .trig_pulse (trig_pulse),
    .adc_req    (adc_req),
    .load       (load),
    .load_data  (load_data)
  );

  beam_result_bank #(.CODE_W(CODE_W)) i_bank (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (load_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .res       (res),
    .fresh     (fresh)
  );

  assign res_red = res[CH_RED];
  assign res_grn = res[CH_GRN];
  assign res_blu = res[CH_BLU];
endmodule

// File: tb/test_beam_sampler_top.sv
module test_beam_sampler_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync_in = 1'b0;
  logic        vsync_in = 1'b0;
  logic        flyback_in = 1'b0;
  logic [11:0] trig_line = '0;
  logic [2:0]  adc_req;
  logic [2:0]  adc_valid;
  logic [2:0]  model_valid = '0;
  logic [2:0]  stray_valid = '0;
  logic [7:0]  adc_code_red, adc_code_grn, adc_code_blu;
  logic        trig_pulse;
  logic [7:0]  res_red, res_grn, res_blu;
  logic        fresh;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;

  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [23:0] exp_q[$];
  logic [23:0] exp_prev = '0;
  logic [7:0]  code_now [3];
  int          lat [3] = '{3, 7, 40};
  int          wait_cnt [3] = '{0, 0, 0};
  int          trig_cnt = 0;
  int          req_cnt [3] = '{0, 0, 0};
  bit          conv_open = 1'b0;
  logic        fresh_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign adc_valid    = model_valid | stray_valid;
  assign adc_code_red = model_valid[0] ? code_now[0] : 8'hEE;
  assign adc_code_grn = model_valid[1] ? code_now[1] : 8'hEE;
  assign adc_code_blu = model_valid[2] ? code_now[2] : 8'hEE;

  beam_sampler_top i_beam_sampler_top (
    .clk (clk), .rst (rst),
    .hsync_in (hsync_in), .vsync_in (vsync_in), .flyback_in (flyback_in),
    .trig_line (trig_line),
    .adc_req (adc_req), .adc_valid (adc_valid),
    .adc_code_red (adc_code_red), .adc_code_grn (adc_code_grn), .adc_code_blu (adc_code_blu),
    .trig_pulse (trig_pulse),
    .res_red (res_red), .res_grn (res_grn), .res_blu (res_blu),
    .fresh (fresh),
    .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model: fixed latency per channel
  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      model_valid[i] <= 1'b0;
      if (adc_req[i]) begin
        wait_cnt[i] <= lat[i];
      end else if (wait_cnt[i] > 0) begin
        wait_cnt[i] <= wait_cnt[i] - 1;
        if (wait_cnt[i] == 1) model_valid[i] <= 1'b1;
      end
    end
  end

  // monitor: event counters and scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (trig_pulse) trig_cnt++;
      for (int i = 0; i < 3; i++) if (adc_req[i]) req_cnt[i]++;
      if (adc_req[0]) conv_open = 1'b1;
      if (conv_open && model_valid[1])
        check({res_red, res_grn, res_blu} == exp_prev, "R6 partial set held",
              {res_red, res_grn, res_blu}, exp_prev);
      if (fresh && !fresh_prev) begin
        conv_open = 1'b0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected result store", {res_red, res_grn, res_blu}, 0);
        end else begin
          exp_prev = exp_q.pop_front();
          check({res_red, res_grn, res_blu} == exp_prev, "R6 stored set",
                {res_red, res_grn, res_blu}, exp_prev);
        end
      end
      fresh_prev = fresh;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fly();
    flyback_in = 1'b1; cyc(4); flyback_in = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    cyc(1);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic run_frame(input int tl, input int nlines, input logic [7:0] r,
                           input logic [7:0] g, input logic [7:0] b,
                           input bit capture, input bit dbl);
    trig_line = 12'(tl);
    code_now[0] = r; code_now[1] = g; code_now[2] = b;
    if (capture) exp_q.push_back({r, g, b});
    vsync_in = 1'b1; cyc(4); vsync_in = 1'b0; cyc(4);
    pulse_fly(); cyc(6);
    for (int i = 0; i < nlines; i++) begin
      hsync_in = 1'b1; cyc(3); hsync_in = 1'b0; cyc(3);
      pulse_fly(); cyc(6);
      if (dbl) begin cyc(50); pulse_fly(); cyc(6); end
    end
    cyc(60);
  endtask

  task automatic frame_checks(input string tag, input int t0, input int q0, input int q1,
                              input int q2, input logic [7:0] r, input logic [7:0] g,
                              input logic [7:0] b);
    logic [7:0] d;
    check(trig_cnt - t0 == 1, {tag, " R3 one trig pulse"}, trig_cnt - t0, 1);
    check((req_cnt[0] - q0 == 1) && (req_cnt[1] - q1 == 1) && (req_cnt[2] - q2 == 1),
          {tag, " R3 one request per channel"}, req_cnt[0] - q0, 1);
    check(fresh == 1'b1, {tag, " R8 fresh set"}, fresh, 1);
    rd(2'd3, d); check(d == 8'h01, {tag, " R9 status read"}, d, 1);
    rd(2'd1, d); check(d == g, {tag, " R9 green read"}, d, g);
    rd(2'd2, d); check(d == b, {tag, " R9 blue read"}, d, b);
    rd(2'd0, d); check(d == r, {tag, " R9 red read"}, d, r);
    check(fresh == 1'b0, {tag, " R8 fresh cleared by red read"}, fresh, 0);
    rd(2'd3, d); check(d == 8'h00, {tag, " R9 status after clear"}, d, 0);
  endtask

  initial begin
    logic [7:0] d;
    int t0, q0, q1, q2;
    cyc(5);
    rst = 1'b0;
    cyc(2);
    // R1 reset state
    check({res_red, res_grn, res_blu} == 24'h0, "R1 results zero", {res_red, res_grn, res_blu}, 0);
    check(fresh == 1'b0, "R1 fresh zero", fresh, 0);
    check(adc_req == 3'b000 && trig_pulse == 1'b0, "R1 no strobes", adc_req, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); check(d == 8'h00, "R1 read zero", d, 0);
    end

    // R3 not armed before any vsync edge
    t0 = trig_cnt; q0 = req_cnt[0];
    trig_line = 12'd0;
    pulse_fly(); cyc(10); pulse_fly(); cyc(60);
    check(trig_cnt == t0 && req_cnt[0] == q0, "R3 no capture before vsync", trig_cnt - t0, 0);

    // mid-frame trigger line
    t0 = trig_cnt; q0 = req_cnt[0]; q1 = req_cnt[1]; q2 = req_cnt[2];
    run_frame(3, 8, 8'h11, 8'h22, 8'h33, 1'b1, 1'b0);
    frame_checks("R2 line3", t0, q0, q1, q2, 8'h11, 8'h22, 8'h33);

    // line 0: flyback before first hsync
    t0 = trig_cnt; q0 = req_cnt[0]; q1 = req_cnt[1]; q2 = req_cnt[2];
    run_frame(0, 6, 8'hA5, 8'h5A, 8'hC3, 1'b1, 1'b0);
    frame_checks("R2 line0", t0, q0, q1, q2, 8'hA5, 8'h5A, 8'hC3);

    // R4 two flybacks per line, second after conversion finished
    t0 = trig_cnt; q0 = req_cnt[0]; q1 = req_cnt[1]; q2 = req_cnt[2];
    run_frame(5, 7, 8'h01, 8'h80, 8'hFF, 1'b1, 1'b1);
    frame_checks("R4 double flyback", t0, q0, q1, q2, 8'h01, 8'h80, 8'hFF);

    // R5 trigger line never reached
    t0 = trig_cnt;
    run_frame(20, 8, 8'h99, 8'h98, 8'h97, 1'b0, 1'b0);
    check(trig_cnt == t0, "R5 no trig pulse", trig_cnt - t0, 0);
    check({res_red, res_grn, res_blu} == exp_prev, "R5 results kept",
          {res_red, res_grn, res_blu}, exp_prev);
    check(fresh == 1'b0, "R5 fresh unchanged", fresh, 0);

    // R7 unsolicited valid strobes
    stray_valid = 3'b111; cyc(1); stray_valid = 3'b000; cyc(4);
    check({res_red, res_grn, res_blu} == exp_prev, "R7 stray valid ignored",
          {res_red, res_grn, res_blu}, exp_prev);
    check(fresh == 1'b0, "R7 fresh unchanged", fresh, 0);

    // last line of the frame
    t0 = trig_cnt; q0 = req_cnt[0]; q1 = req_cnt[1]; q2 = req_cnt[2];
    run_frame(8, 8, 8'h7E, 8'hE7, 8'h3C, 1'b1, 1'b0);
    frame_checks("R2 line8", t0, q0, q1, q2, 8'h7E, 8'hE7, 8'h3C);

    check(exp_q.size() == 0, "R3 all expected sets seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule